// File: doc/BRIEF.md
# Bytecode Extended Folding Decoder

This decode-stage unit sits after instruction fetch in a stack-machine core that keeps the top of each frame in a register-file stack cache. Each cycle it looks at a six-byte window of upcoming bytecode and splits it into up to three instructions. When the leading instructions form a recognised group, it merges them into one register-to-register micro-operation. A group is pushes of locals or constants, followed by an integer ALU operation, optionally followed by a store to a local. The micro-operation reads its operands straight from register-file slots or from immediates, not from the top-of-stack and next-on-stack registers. This removes the redundant stack shuffling of a pure stack machine.

Local-variable slots become register-file addresses by adding their index to the frame's local-variable base. Two adders work in parallel, so a group may name two locals in one cycle. If a local in the chosen group is not resident in the stack cache, folding is abandoned and only the first instruction issues. The unit reports how many instructions and how many bytes it consumed, so fetch can advance over two-byte forms. The result is registered and appears one cycle after the window is presented.

Top module: `fold_decoder`

## Requirements
- R1: A window that starts load, load, arith folds into one operation with count 3. Operand A is the first load and operand B is the second load. The op field is the arith opcode.
- R2: A window that starts load, arith, store folds with count 3. Operand A is the stack top (mode 0), operand B is the load, `wr_en`=1, and `wr_addr` is the store's slot address.
- R3: A window that starts load, arith, with no store following, folds with count 2. Operand A is the stack top and operand B is the load.
- R4: A window that starts arith, store folds with count 2. Both operands are stack operands (mode 0), and the result is written to the store's slot address.
- R5: The longest matching group wins: three-instruction groups beat two-instruction groups, which beat single issue. Without a match, count is 1, the op field is the first opcode, both modes are 0, and `wr_en`=0. This also applies to opcodes outside the supported set, which are taken as one byte long.
- R6: Only fully valid instructions take part in matching. An instruction whose bytes are not all flagged valid ends the group. If the first instruction is incomplete, `out_vld`=0 and every output field is 0.
- R7: A group is not folded if any local it reads or writes has an index at or above `resid_cnt`. Only the first instruction then issues alone.
- R8: Slot addresses are `lv_base` + index, modulo 2^AW. Two such addresses come from separate adders in the same cycle.
- R9: Supported opcodes (hex): loads of locals 1A–1D (index 0–3) and 15 with an index byte. Constants 02–08 give values −1..5, and 10 gives a signed byte. Arith ops are 60, 64, 7E, 80, 82. Stores are 3B–3E (index 0–3) and 36 with an index byte. Modes are 0 = stack, 1 = register, 2 = immediate, with the immediate as an 8-bit two's-complement value.
- R10: `out_cnt` is the number of instructions consumed (1–3). `out_len` is their total byte length.
- R11: During reset every output is 0.
- R12: Each window's result is presented on the outputs in the cycle after the edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_data | input | 48 | Bytecode window, byte k at bits 8k+7:8k |
| win_vld | input | 6 | Per-byte valid flags |
| lv_base | input | AW | Local-variable base register address |
| resid_cnt | input | 8 | Number of locals resident in the stack cache |
| out_vld | output | 1 | Micro-operation valid |
| out_cnt | output | 2 | Instructions consumed |
| out_len | output | 3 | Bytes consumed |
| out_op | output | 8 | ALU opcode of a fold, or first opcode on single issue |
| a_mode | output | 2 | Operand A source |
| a_addr | output | AW | Operand A register address |
| a_imm | output | 8 | Operand A immediate |
| b_mode | output | 2 | Operand B source |
| b_addr | output | AW | Operand B register address |
| b_imm | output | 8 | Operand B immediate |
| wr_en | output | 1 | Result written to a local |
| wr_addr | output | AW | Destination register address |

## Verification
The only state is the single output register, so any decode fault shows up in the cycle after the faulty window. A mis-split instruction boundary appears as a wrong `out_len` or a shifted opcode in `out_op`. A wrong pattern priority appears as a short `out_cnt`. A missed residency check appears as a fold where single issue was due. An adder or routing fault puts a register address on the wrong operand or breaks the wrap at the top of the register file. The windows chosen separate these faults: partial windows, non-resident sources and destinations, two-byte forms in every position, and a base near the wrap point.

// File: rtl/fold_decoder.sv
module fold_decoder #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [47:0]   win_data,
  input  logic [5:0]    win_vld,
  input  logic [AW-1:0] lv_base,
  input  logic [7:0]    resid_cnt,
  output logic          out_vld,
  output logic [1:0]    out_cnt,
  output logic [2:0]    out_len,
  output logic [7:0]    out_op,
  output logic [1:0]    a_mode,
  output logic [AW-1:0] a_addr,
  output logic [7:0]    a_imm,
  output logic [1:0]    b_mode,
  output logic [AW-1:0] b_addr,
  output logic [7:0]    b_imm,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);

  localparam logic [2:0] C_OTH = 3'd0, C_LV = 3'd1, C_K = 3'd2, C_AR = 3'd3, C_ST = 3'd4;
  localparam logic [1:0] M_STK = 2'd0, M_REG = 2'd1, M_IMM = 2'd2;

  function automatic logic [2:0] cls(input logic [7:0] op);
    if ((op >= 8'h1a && op <= 8'h1d) || op == 8'h15) return C_LV;
    if ((op >= 8'h02 && op <= 8'h08) || op == 8'h10) return C_K;
    if (op == 8'h60 || op == 8'h64 || op == 8'h7e || op == 8'h80 || op == 8'h82) return C_AR;
    if ((op >= 8'h3b && op <= 8'h3e) || op == 8'h36) return C_ST;
    return C_OTH;
  endfunction

  function automatic logic [7:0] arg(input logic [7:0] op, input logic [7:0] nb);
    if (op >= 8'h1a && op <= 8'h1d) return op - 8'h1a;
    if (op >= 8'h02 && op <= 8'h08) return op - 8'h03;
    if (op >= 8'h3b && op <= 8'h3e) return op - 8'h3b;
    return nb;
  endfunction

  logic [7:0] op [3];
  logic [7:0] val [3];
  logic [2:0] cl [3];
  logic [1:0] ln [3];
  logic       iv [3];
  logic [2:0] pos_end;

  always_comb begin
    logic [63:0] d;
    logic [7:0]  v;
    logic [2:0]  pos;
    logic        ok;
    d   = {16'h0, win_data};
    v   = {2'b00, win_vld};
    pos = 3'd0;
    ok  = 1'b1;
    for (int k = 0; k < 3; k++) begin
      op[k]  = d[{pos, 3'b000} +: 8];
      ln[k]  = (op[k] == 8'h15 || op[k] == 8'h10 || op[k] == 8'h36) ? 2'd2 : 2'd1;
      val[k] = arg(op[k], d[{pos + 3'd1, 3'b000} +: 8]);
      cl[k]  = cls(op[k]);
      ok     = ok && v[pos] && (ln[k] == 2'd1 || v[pos + 3'd1]);
      iv[k]  = ok;
      pos    = pos + {1'b0, ln[k]};
    end
    pos_end = pos;
  end

  wire ld0 = cl[0] == C_LV || cl[0] == C_K;
  wire ld1 = cl[1] == C_LV || cl[1] == C_K;
  wire p_lla = iv[2] && ld0 && ld1 && cl[2] == C_AR;
  wire p_las = iv[2] && ld0 && cl[1] == C_AR && cl[2] == C_ST;
  wire p_la  = iv[1] && ld0 && cl[1] == C_AR;
  wire p_as  = iv[1] && cl[0] == C_AR && cl[1] == C_ST;

  wire [7:0] idx0 = p_as ? val[1] : val[0];
  wire [7:0] idx1 = p_lla ? val[1] : val[2];
  wire use0 = p_as || ((p_lla || p_las || p_la) && cl[0] == C_LV);
  wire use1 = (p_lla && cl[1] == C_LV) || (!p_lla && p_las);
  wire res_ok = !(use0 && idx0 >= resid_cnt) && !(use1 && idx1 >= resid_cnt);
  wire fold = (p_lla || p_las || p_la || p_as) && res_ok;

  wire [AW-1:0] sum0 = lv_base + idx0[AW-1:0];
  wire [AW-1:0] sum1 = lv_base + idx1[AW-1:0];

  wire [1:0]  m0 = (cl[0] == C_LV) ? M_REG : M_IMM;
  wire [1:0]  m1 = (cl[1] == C_LV) ? M_REG : M_IMM;
  wire [AW-1:0] ad0 = (cl[0] == C_LV) ? sum0 : '0;
  wire [7:0]  im0 = (cl[0] == C_K) ? val[0] : 8'h0;

  always_ff @(posedge clk) begin
    out_vld <= 1'b0; out_cnt <= 2'd0; out_len <= 3'd0; out_op <= 8'h0;
    a_mode <= M_STK; a_addr <= '0; a_imm <= 8'h0;
    b_mode <= M_STK; b_addr <= '0; b_imm <= 8'h0;
    wr_en <= 1'b0; wr_addr <= '0;
    if (rst_n && iv[0]) begin
      out_vld <= 1'b1;
      if (fold && p_lla) begin
        out_cnt <= 2'd3; out_len <= pos_end; out_op <= op[2];
        a_mode <= m0; a_addr <= ad0; a_imm <= im0;
        b_mode <= m1;
        b_addr <= (cl[1] == C_LV) ? sum1 : '0;
        b_imm  <= (cl[1] == C_K) ? val[1] : 8'h0;
      end else if (fold && p_las) begin
        out_cnt <= 2'd3; out_len <= pos_end; out_op <= op[1];
        b_mode <= m0; b_addr <= ad0; b_imm <= im0;
        wr_en <= 1'b1; wr_addr <= sum1;
      end else if (fold && p_la) begin
        out_cnt <= 2'd2; out_len <= {1'b0, ln[0]} + 3'd1; out_op <= op[1];
        b_mode <= m0; b_addr <= ad0; b_imm <= im0;
      end else if (fold && p_as) begin
        out_cnt <= 2'd2; out_len <= 3'd1 + {1'b0, ln[1]}; out_op <= op[0];
        wr_en <= 1'b1; wr_addr <= sum0;
      end else begin
        out_cnt <= 2'd1; out_len <= {1'b0, ln[0]}; out_op <= op[0];
      end
    end
  end

  // R10
  cnt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (out_cnt != 2'd0 && out_len >= {1'b0, out_cnt} && out_len <= {out_cnt, 1'b0}));

  // R6
  window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (32'(out_len) <= $past($countones(win_vld))));

  // R12
  empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_vld[0] |=> !out_vld);

  // R5
  single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_cnt == 2'd1) |-> (a_mode == M_STK && b_mode == M_STK && !wr_en));

  // R7
  resid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && wr_en) |-> (8'(AW'(wr_addr - $past(lv_base))) < $past(resid_cnt)));

endmodule

// File: tb/fold_decoder_test.sv
module fold_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] win_data = '0;
  logic [5:0]  win_vld = '0;
  logic [4:0]  lv_base = '0;
  logic [7:0]  resid_cnt = '0;
  logic        out_vld, wr_en;
  logic [1:0]  out_cnt, a_mode, b_mode;
  logic [2:0]  out_len;
  logic [7:0]  out_op, a_imm, b_imm;
  logic [4:0]  a_addr, b_addr, wr_addr;

  fold_decoder #(.AW(5)) uut (
    .clk(clk), .rst_n(rst_n), .win_data(win_data), .win_vld(win_vld),
    .lv_base(lv_base), .resid_cnt(resid_cnt),
    .out_vld(out_vld), .out_cnt(out_cnt), .out_len(out_len), .out_op(out_op),
    .a_mode(a_mode), .a_addr(a_addr), .a_imm(a_imm),
    .b_mode(b_mode), .b_addr(b_addr), .b_imm(b_imm),
    .wr_en(wr_en), .wr_addr(wr_addr));

  always #2 clk = ~clk;

  typedef struct packed {
    logic vld; logic [1:0] cnt; logic [2:0] len; logic [7:0] op;
    logic [1:0] am; logic [4:0] aa; logic [7:0] ai;
    logic [1:0] bm; logic [4:0] ba; logic [7:0] bi;
    logic we; logic [4:0] wa;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;

  function automatic exp_t got();
    return '{out_vld, out_cnt, out_len, out_op, a_mode, a_addr, a_imm,
             b_mode, b_addr, b_imm, wr_en, wr_addr};
  endfunction

  function automatic exp_t mk(logic [1:0] c, logic [2:0] l, logic [7:0] o,
                              logic [1:0] am, logic [4:0] aa, logic [7:0] ai,
                              logic [1:0] bm, logic [4:0] ba, logic [7:0] bi,
                              logic we, logic [4:0] wa);
    return '{1'b1, c, l, o, am, aa, ai, bm, ba, bi, we, wa};
  endfunction

  task automatic push(input logic [47:0] d, input logic [5:0] v, input logic [4:0] base,
                      input logic [7:0] res, input exp_t e, input string tag);
    @(negedge clk);
    win_data = d; win_vld = v; lv_base = base; resid_cnt = res;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // R12: each pushed window is compared just after the next rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        exp_t a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = got();
        n_chk++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    win_vld = 6'h3f; win_data = 48'h0000_00601c1b;
    repeat (3) @(negedge clk);
    n_chk++;
    if (got() !== '0) begin
      n_fail++;
      $display("FAIL R11: actual %h expected %h", got(), exp_t'('0));
    end
    rst_n = 1'b1;
    // R1 two locals
    push(48'h0000_00601c1b, 6'b000111, 5'd4, 8'd8, mk(3, 3, 8'h60, 1, 5, 0, 1, 6, 0, 0, 0), "R1");
    // R1 R9 wide load and constant
    push(48'h0000_64050715, 6'b001111, 5'd4, 8'd8, mk(3, 4, 8'h64, 1, 11, 0, 2, 0, 8'h02, 0, 0), "R1");
    // R2
    push(48'h0000_003e7e1a, 6'b000111, 5'd4, 8'd8, mk(3, 3, 8'h7e, 0, 0, 0, 1, 4, 0, 1, 7), "R2");
    // R2 R9 bipush and wide store, R10 length 5
    push(48'h0006_3680fd10, 6'b011111, 5'd4, 8'd8, mk(3, 5, 8'h80, 0, 0, 0, 2, 0, 8'hfd, 1, 10), "R2");
    // R3 R9 constant -1
    push(48'h0000_00008202, 6'b000111, 5'd4, 8'd8, mk(2, 2, 8'h82, 0, 0, 0, 2, 0, 8'hff, 0, 0), "R3");
    // R4
    push(48'h0000_00003d60, 6'b000111, 5'd4, 8'd8, mk(2, 2, 8'h60, 0, 0, 0, 0, 0, 0, 1, 6), "R4");
    // R6 third byte invalid
    push(48'h0000_00601c1b, 6'b000011, 5'd4, 8'd8, mk(1, 1, 8'h1b, 0, 0, 0, 0, 0, 0, 0, 0), "R6");
    // R6 R5 store unseen, falls back to the two-instruction group
    push(48'h0000_003e601a, 6'b000011, 5'd4, 8'd8, mk(2, 2, 8'h60, 0, 0, 0, 1, 4, 0, 0, 0), "R6");
    // R7 non-resident source
    push(48'h0000_00601a1d, 6'b000111, 5'd4, 8'd2, mk(1, 1, 8'h1d, 0, 0, 0, 0, 0, 0, 0, 0), "R7");
    // R7 non-resident destination
    push(48'h0000_003e601a, 6'b000111, 5'd4, 8'd2, mk(1, 1, 8'h1a, 0, 0, 0, 0, 0, 0, 0, 0), "R7");
    // R8 wrap at the register file top
    push(48'h0000_0060031d, 6'b000111, 5'd30, 8'd8, mk(3, 3, 8'h60, 1, 1, 0, 2, 0, 8'h00, 0, 0), "R8");
    // R6 nothing valid
    push(48'h0000_00601c1b, 6'b000000, 5'd4, 8'd8, '0, "R6");
    // R5 unsupported opcode first
    push(48'h0000_003e6000, 6'b000111, 5'd4, 8'd8, mk(1, 1, 8'h00, 0, 0, 0, 0, 0, 0, 0, 0), "R5");
    // R6 incomplete two-byte first instruction
    push(48'h0000_00000010, 6'b000001, 5'd4, 8'd8, '0, "R6");
    // R6 incomplete wide load in second position
    push(48'h0000_6000151a, 6'b000011, 5'd4, 8'd8, mk(1, 1, 8'h1a, 0, 0, 0, 0, 0, 0, 0, 0), "R6");
    // R9 two constants
    push(48'h0000_00640808, 6'b000111, 5'd4, 8'd8, mk(3, 3, 8'h64, 2, 0, 8'h05, 2, 0, 8'h05, 0, 0), "R9");
    // R8 two locals at high indices near wrap
    push(48'h0000_7e1c1d00, 6'b000000, 5'd29, 8'd8, '0, "R6");
    push(48'h0000_007e1c1d, 6'b000111, 5'd29, 8'd8, mk(3, 3, 8'h7e, 1, 0, 0, 1, 31, 0, 0, 0), "R8");
    @(negedge clk);
    win_vld = '0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule